// File: doc/BRIEF.md
# Address-Keyed Stall and Wake Buffer

This block sits in front of a cache line controller and holds core requests that cannot be served yet because their line is mid-transaction. The controller inspects the request offered on the core channel and raises `in_park` when the line is transient. The buffer then takes the whole request (kind, address, requester number, byte mask and flags) into a slot instead of passing it on. A parked request makes no attempt to proceed on its own. It stays put until the controller pulses `wake_valid` with the line number whose transaction has just finished. Every parked request for that line becomes eligible in that one event, and the eligible requests are replayed on the output stream in the order they first arrived.

Both the core side and the controller side are valid/ready streams. A request that is not parked flows straight through in the same cycle, so `in_ready` then follows `out_ready`. Replays take precedence: while any released request is waiting, the input is held off and the output carries the replay, marked by `out_replay`. A replay that meets low `out_ready` keeps its fields unchanged until it is taken. The input also refuses requests, parked or not, while every slot is occupied.

Matching uses only the line number, which is the address bits above the line offset. The decision to park comes from the controller and needs no tag lookup here, so the buffer never waits on a tag-array resource.

Top module: `stw_buffer`

## Requirements
- R1: After reset the buffer is empty: `out_valid` is 0 and, with `out_ready` high and the input idle, `in_ready` is 1.
- R2: A request with `in_valid`, `in_park` and `in_ready` high at a clock edge is stored, and it does not appear on the output in that cycle.
- R3: With no released request pending and the buffer not full, a request with `in_park` low appears on the output in the same cycle with `out_replay` 0, and `in_ready` equals `out_ready`.
- R4: A parked request never reaches the output until a wake arrives whose `wake_line` equals the parked address bits [31:6].
- R5: One wake releases every parked request for that line, and requests for other lines stay parked.
- R6: Released requests are replayed one per accepted output transfer, oldest arrival first, with `out_replay` 1.
- R7: While any released request is waiting, `in_ready` is 0 and the output carries the replay instead of the input.
- R8: With 8 requests parked, `in_ready` is 0 and no non-parked request passes to the output.
- R9: A wake for a line with no parked request changes nothing: no replay appears and pass-through behaves as before.
- R10: A request parked in the same cycle as a wake for its line is released by that wake and replays next cycle.
- R11: A replay offered while `out_ready` is low keeps `out_valid` and all its fields unchanged until it is taken.
- R12: Replay delivers kind (0 read, 1 write, 2 atomic), address, requester number, byte mask and flags exactly as parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Core request offered |
| in_ready | output | 1 | Core request accepted this cycle |
| in_park | input | 1 | Controller decision: park the offered request |
| in_kind | input | 2 | Request kind: 0 read, 1 write, 2 atomic |
| in_addr | input | 32 | Request byte address |
| in_rid | input | 6 | Requester number |
| in_mask | input | 16 | Byte mask |
| in_flags | input | 2 | Cache-policy flags |
| wake_valid | input | 1 | Line transaction completed this cycle |
| wake_line | input | 26 | Line number (address bits [31:6]) that completed |
| out_valid | output | 1 | Request offered to the controller |
| out_ready | input | 1 | Controller takes the offered request |
| out_replay | output | 1 | Offered request is a replay from the buffer |
| out_kind | output | 2 | Offered request kind |
| out_addr | output | 32 | Offered request address |
| out_rid | output | 6 | Offered requester number |
| out_mask | output | 16 | Offered byte mask |
| out_flags | output | 2 | Offered flags |

## Verification
The delicate overlap is parking and waking in the same cycle for the same line: a request accepted into a slot on the very edge at which its line completes must not be stranded. The bench drives `in_park` with a new request and `wake_valid` for that request's line together, then expects the request as a replay on the next cycle. It also lets a wake coincide with a stalled replay and with a new input request, and judges that the replay stays fixed and the input stays blocked.

// File: rtl/stw_pkg.sv
package stw_pkg;
  localparam int KIND_W   = 2;
  localparam int ADDR_W   = 32;
  localparam int RID_W    = 6;
  localparam int MASK_W   = 16;
  localparam int FLAG_W   = 2;
  localparam int LINE_OFF = 6;
  localparam int LINE_W   = ADDR_W - LINE_OFF;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic [ADDR_W-1:0] addr;
    logic [RID_W-1:0]  rid;
    logic [MASK_W-1:0] mask;
    logic [FLAG_W-1:0] flags;
  } stw_req_t;

  localparam int REQ_W = $bits(stw_req_t);
endpackage

// File: rtl/stw_line_match.sv
module stw_line_match
  import stw_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic [DEPTH-1:0][LINE_W-1:0] ent_lines,
  input  logic [DEPTH-1:0]             occ,
  input  logic                         wake_valid,
  input  logic [LINE_W-1:0]            wake_line,
  input  logic [LINE_W-1:0]            in_line,
  output logic [DEPTH-1:0]             hit,
  output logic                         in_hit
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit[g] = wake_valid && occ[g] && (ent_lines[g] == wake_line);
  end
  assign in_hit = wake_valid && (in_line == wake_line);
endmodule

// File: rtl/stw_oldest_pick.sv
module stw_oldest_pick #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/stw_slot_store.sv
module stw_slot_store
  import stw_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  stw_req_t                    push_req,
  input  logic                        push_woke,
  input  logic                        pop,
  input  logic [IDX_W-1:0]            pop_idx,
  input  logic [DEPTH-1:0]            mark,
  output stw_req_t [DEPTH-1:0]        ents,
  output logic [DEPTH-1:0]            woke,
  output logic [DEPTH-1:0]            occ,
  output logic [CNT_W-1:0]            count
);
  stw_req_t [DEPTH-1:0] ents_q, ents_n, ents_sh;
  logic [DEPTH-1:0]     woke_q, woke_n, wmark, wmark_sh;
  logic [CNT_W-1:0]     count_q, count_n, tail;

  for (genvar g = 0; g < DEPTH; g++) begin : g_occ
    assign occ[g] = (count_q > CNT_W'(g));
  end

  always_comb begin
    wmark    = woke_q | mark;
    ents_sh  = ents_q >> REQ_W;
    wmark_sh = wmark >> 1;
    ents_n   = ents_q;
    woke_n   = wmark;
    if (pop) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i >= int'(pop_idx)) begin
          ents_n[i] = ents_sh[i];
          woke_n[i] = wmark_sh[i];
        end
      end
    end
    tail = count_q - CNT_W'(pop);
    if (push) begin
      ents_n[tail[IDX_W-1:0]] = push_req;
      woke_n[tail[IDX_W-1:0]] = push_woke;
    end
    count_n = count_q + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ents_q  <= '0;
      woke_q  <= '0;
      count_q <= '0;
    end else begin
      ents_q  <= ents_n;
      woke_q  <= woke_n;
      count_q <= count_n;
    end
  end

  assign ents  = ents_q;
  assign woke  = woke_q;
  assign count = count_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) count_q <= CNT_W'(DEPTH)); // R8
  AST_POP_ONLY_WOKEN: assert property (@(posedge clk) disable iff (!rst_n) pop |-> woke_q[pop_idx]); // R4
endmodule

// File: rtl/stw_buffer.sv
module stw_buffer
  import stw_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_park,
  input  logic [KIND_W-1:0] in_kind,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [RID_W-1:0]  in_rid,
  input  logic [MASK_W-1:0] in_mask,
  input  logic [FLAG_W-1:0] in_flags,
  input  logic              wake_valid,
  input  logic [LINE_W-1:0] wake_line,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_replay,
  output logic [KIND_W-1:0] out_kind,
  output logic [ADDR_W-1:0] out_addr,
  output logic [RID_W-1:0]  out_rid,
  output logic [MASK_W-1:0] out_mask,
  output logic [FLAG_W-1:0] out_flags
);
  stw_req_t                    in_req, sel_req;
  stw_req_t [DEPTH-1:0]        ents;
  logic [DEPTH-1:0][LINE_W-1:0] ent_lines;
  logic [DEPTH-1:0]            occ, woke, hit;
  logic [CNT_W-1:0]            count;
  logic                        in_hit, rep_valid, full, pass_ok, push, pop;
  logic [IDX_W-1:0]            enc_idx, pick, lk_idx;
  logic                        lk_valid;

  assign in_req = '{kind: in_kind, addr: in_addr, rid: in_rid, mask: in_mask, flags: in_flags};

  for (genvar g = 0; g < DEPTH; g++) begin : g_line
    assign ent_lines[g] = ents[g].addr[ADDR_W-1:LINE_OFF];
  end

  stw_line_match #(.DEPTH(DEPTH)) u_match (
    .ent_lines (ent_lines),
    .occ       (occ),
    .wake_valid(wake_valid),
    .wake_line (wake_line),
    .in_line   (in_addr[ADDR_W-1:LINE_OFF]),
    .hit       (hit),
    .in_hit    (in_hit)
  );

  stw_oldest_pick #(.N(DEPTH)) u_pick (
    .vec(woke),
    .any(rep_valid),
    .idx(enc_idx)
  );

  stw_slot_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_req (in_req),
    .push_woke(in_hit),
    .pop      (pop),
    .pop_idx  (pick),
    .mark     (hit),
    .ents     (ents),
    .woke     (woke),
    .occ      (occ),
    .count    (count)
  );

  assign full     = (count == CNT_W'(DEPTH));
  assign pick     = lk_valid ? lk_idx : enc_idx;
  assign pass_ok  = in_valid && !in_park && !full && !rep_valid;
  assign in_ready = !full && !rep_valid && (in_park || out_ready);
  assign push     = in_valid && in_park && in_ready;
  assign pop      = rep_valid && out_ready;

  assign sel_req    = rep_valid ? ents[pick] : in_req;
  assign out_valid  = rep_valid || pass_ok;
  assign out_replay = rep_valid;
  assign out_kind   = sel_req.kind;
  assign out_addr   = sel_req.addr;
  assign out_rid    = sel_req.rid;
  assign out_mask   = sel_req.mask;
  assign out_flags  = sel_req.flags;

  // A stalled replay keeps its slot so a later wake cannot swap it out.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_valid <= 1'b0;
      lk_idx   <= '0;
    end else begin
      lk_valid <= rep_valid && !out_ready;
      lk_idx   <= pick;
    end
  end

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (count == CNT_W'(DEPTH)) |-> !in_ready); // R8
  AST_REPLAY_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_replay) |-> !in_ready); // R7
  AST_REPLAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_replay && !out_ready) |=> (out_valid && out_replay && $stable(out_addr) && $stable(out_rid))); // R11
  AST_PARK_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_park && in_ready) |-> !out_valid); // R2
endmodule

// File: tb/stw_buffer_tb.sv
module stw_buffer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_park;
  logic [1:0]  in_kind;
  logic [31:0] in_addr;
  logic [5:0]  in_rid;
  logic [15:0] in_mask;
  logic [1:0]  in_flags;
  logic        wake_valid;
  logic [25:0] wake_line;
  logic        out_valid, out_ready, out_replay;
  logic [1:0]  out_kind;
  logic [31:0] out_addr;
  logic [5:0]  out_rid;
  logic [15:0] out_mask;
  logic [1:0]  out_flags;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stw_buffer u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_park(in_park),
    .in_kind(in_kind), .in_addr(in_addr), .in_rid(in_rid),
    .in_mask(in_mask), .in_flags(in_flags),
    .wake_valid(wake_valid), .wake_line(wake_line),
    .out_valid(out_valid), .out_ready(out_ready), .out_replay(out_replay),
    .out_kind(out_kind), .out_addr(out_addr), .out_rid(out_rid),
    .out_mask(out_mask), .out_flags(out_flags)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_in;
    in_valid = 0; in_park = 0; in_kind = 0; in_addr = 0;
    in_rid = 0; in_mask = 0; in_flags = 0;
  endtask

  task automatic park(logic [1:0] k, logic [31:0] a, logic [5:0] r, logic [15:0] m, logic [1:0] f);
    in_valid = 1; in_park = 1; in_kind = k; in_addr = a;
    in_rid = r; in_mask = m; in_flags = f;
    #1;
    chk("R2", "in_ready on park", in_ready, 1);
    chk("R2", "out_valid on park", out_valid, 0);
    tick;
    idle_in;
  endtask

  task automatic wake(logic [25:0] line);
    wake_valid = 1; wake_line = line;
    tick;
    wake_valid = 0;
  endtask

  task automatic expect_replay(string tag, logic [31:0] a, logic [5:0] r);
    #1;
    chk(tag, "out_valid", out_valid, 1);
    chk(tag, "out_replay", out_replay, 1);
    chk(tag, "out_addr", out_addr, a);
    chk(tag, "out_rid", out_rid, r);
    tick;
  endtask

  task automatic t_reset;
    #1;
    chk("R1", "out_valid after reset", out_valid, 0);
    chk("R1", "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_pass;
    in_valid = 1; in_park = 0; in_addr = 32'h0000_1234; in_rid = 6'd9; in_kind = 2'd1;
    #1;
    chk("R3", "pass out_valid", out_valid, 1);
    chk("R3", "pass out_replay", out_replay, 0);
    chk("R3", "pass out_addr", out_addr, 32'h0000_1234);
    chk("R3", "pass in_ready", in_ready, 1);
    out_ready = 0;
    #1;
    chk("R3", "pass in_ready follows out_ready", in_ready, 0);
    out_ready = 1;
    tick;
    idle_in;
  endtask

  task automatic t_order;
    park(2'd2, 32'h0000_0404, 6'd1, 16'hA5A5, 2'd3);   // line 0x10
    park(2'd0, 32'h0000_0800, 6'd2, 16'h0001, 2'd0);   // line 0x20
    park(2'd1, 32'h0000_0430, 6'd3, 16'hFF00, 2'd1);   // line 0x10
    for (int i = 0; i < 3; i++) begin
      #1; chk("R4", "no self retry", out_valid, 0);
      tick;
    end
    wake(26'h33);
    #1; chk("R9", "unmatched wake no replay", out_valid, 0);
    in_valid = 1; in_park = 0; in_addr = 32'h0000_2000; in_rid = 6'd7;
    #1;
    chk("R9", "pass after unmatched wake replay flag", out_replay, 0);
    chk("R9", "pass after unmatched wake addr", out_addr, 32'h0000_2000);
    tick;
    idle_in;
    wake(26'h10);
    in_valid = 1; in_park = 0; in_addr = 32'h0000_3000; in_rid = 6'd8;
    #1;
    chk("R7", "input blocked during replay", in_ready, 0);
    chk("R12", "kind kept", out_kind, 2);
    chk("R12", "mask kept", out_mask, 16'hA5A5);
    chk("R12", "flags kept", out_flags, 3);
    expect_replay("R6", 32'h0000_0404, 6'd1);
    expect_replay("R5", 32'h0000_0430, 6'd3);
    #1;
    chk("R5", "other line stays parked", out_replay, 0);
    chk("R5", "input resumes", out_addr, 32'h0000_3000);
    tick;
    idle_in;
    wake(26'h20);
    expect_replay("R5", 32'h0000_0800, 6'd2);
    #1; chk("R5", "empty after drain", out_valid, 0);
  endtask

  task automatic t_hold;
    park(2'd0, 32'h0000_1000, 6'd11, 16'h1, 2'd0);     // line 0x40
    park(2'd0, 32'h0000_1400, 6'd12, 16'h1, 2'd0);     // line 0x50
    wake(26'h50);
    out_ready = 0;
    #1; chk("R11", "stalled replay addr", out_addr, 32'h0000_1400);
    wake_valid = 1; wake_line = 26'h40;              // older entry released while stalled
    tick;
    wake_valid = 0;
    #1;
    chk("R11", "held valid", out_valid, 1);
    chk("R11", "held addr", out_addr, 32'h0000_1400);
    chk("R11", "held rid", out_rid, 12);
    out_ready = 1;
    expect_replay("R11", 32'h0000_1400, 6'd12);
    expect_replay("R6", 32'h0000_1000, 6'd11);
  endtask

  task automatic t_same_cycle;
    in_valid = 1; in_park = 1; in_addr = 32'h0000_1800; in_rid = 6'd21;
    wake_valid = 1; wake_line = 26'h60;
    tick;
    idle_in; wake_valid = 0;
    expect_replay("R10", 32'h0000_1800, 6'd21);
    #1; chk("R10", "empty after", out_valid, 0);
  endtask

  task automatic t_full;
    for (int i = 0; i < 8; i++) park(2'd1, 32'h0000_1C00 + 32'(i * 4), 6'(30 + i), 16'h3, 2'd0);
    in_valid = 1; in_park = 0; in_addr = 32'h0000_4000;
    #1;
    chk("R8", "in_ready when full", in_ready, 0);
    chk("R8", "no pass when full", out_valid, 0);
    in_park = 1;
    #1; chk("R8", "no park when full", in_ready, 0);
    idle_in;
    wake(26'h70);
    for (int i = 0; i < 8; i++) expect_replay("R6", 32'h0000_1C00 + 32'(i * 4), 6'(30 + i));
    #1; chk("R5", "all released", out_valid, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle_in;
    wake_valid = 0; wake_line = 0; out_ready = 1; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_pass;
    t_order;
    t_hold;
    t_same_cycle;
    t_full;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule